// File: doc/BRIEF.md
# Four-Slot Shared-Bus Grant Arbiter with Favoured-Master Mode

This block decides which of four requesters owns a shared system bus. Each slot raises a request, receives a registered grant, and pulses a done input when its transfer ends. A grant is never taken away before done, so a slow transfer holds the bus for as long as it lasts. The next decision is made in the cycle after the release.

In the default mode the slots take turns in a rotating order. Each winner moves the search start to the slot after it, so with every slot requesting, each one waits for exactly three other transfers. A mode input turns on a favoured-master scheme for the display fetch slot (slot index 3). That slot then alternates with the other three, which take their own turns in rotation. The display slot waits for at most one foreign transfer, and the other slots wait a little longer. The mode input only matters at a decision point.

Top module: `arb_top`

## Requirements
- R1: After reset `gnt` is all zero, and at no time is more than one bit of `gnt` set.
- R2: When the bus is idle and exactly one slot requests, that slot's `gnt` bit is set at the first clock edge that samples the request.
- R3: With `prio_en` low, the search for a winner starts at the slot after the most recently granted slot (slot 0 after reset). With all four slots requesting from reset, grants go 0,1,2,3,0. With only slots 1 and 3 requesting, grants go 1,3,1.
- R4: With `prio_en` high and all slots requesting from reset, grants go 3,0,3,1,3,2,3,0. Slot 3 is the display slot.
- R5: A grant stays unchanged until the granted slot asserts its own `done` bit. A `done` bit from any other slot, a new request, or a change of `prio_en` during the transfer has no effect on `gnt`.
- R6: `gnt` clears at the edge that samples the granted slot's `done`. The next winner's grant appears at the following edge, leaving exactly one cycle with no grant.
- R7: With no request, `gnt` stays zero and the rotation state is kept. After slot 1 alone has been served and the bus has then idled, the first grant among all four requesters goes to slot 2.
- R8: `prio_en` is used only at a decision point. If it is raised and then lowered again during a transfer, the next decision follows the rotating order.
- R9: In favoured mode, if it is the display slot's turn but it is not requesting, a non-display slot is served from its own rotation. With only slots 0 and 2 requesting, grants go 0,2,0. If only the display slot requests, it is granted on every decision.
- R10: A grant is only ever issued to a slot whose request was high at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_en | input | 1 | 1 = display slot alternates with the others; 0 = plain rotation |
| req | input | NUM_SLOTS | Request per slot |
| done | input | NUM_SLOTS | One-cycle end-of-transfer pulse per slot |
| gnt | output | NUM_SLOTS | Registered one-hot grant |

## Verification
A corrupted rotation pointer shows at the ports on the very next decision, as a winner out of the expected order. A wrong favoured-turn flag shows as two foreign transfers in a row, or as the display slot served twice while others wait. A broken hold or release path shows within one cycle of a transfer's end: either the grant fails to drop or the idle cycle goes missing. The directed sequences are therefore long enough to wrap every pointer at least once.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {MODE_ROTATE = 1'b0, MODE_FAVOUR = 1'b1} arb_mode_e;

  // Index of the slot following idx in a ring of n slots.
  function automatic int slot_after(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int s;
      s = int'(start) + k;
      if (s >= N) s = s - N;
      if (!hit && req[s]) begin
        hit = 1'b1;
        idx = IW'(s);
      end
    end
  end
endmodule

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int N   = 4,
  parameter int FAV = 3,
  parameter int IW  = $clog2(N)
) (
  input  arb_mode_e     mode,
  input  logic          fav_turn,
  input  logic          fav_req,
  input  logic          all_hit,
  input  logic [IW-1:0] all_idx,
  input  logic          oth_hit,
  input  logic [IW-1:0] oth_idx,
  output logic          win,
  output logic [IW-1:0] win_idx
);
  always_comb begin
    win     = 1'b0;
    win_idx = '0;
    if (mode == MODE_ROTATE) begin
      win     = all_hit;
      win_idx = all_idx;
    end else if (fav_turn && fav_req) begin
      win     = 1'b1;
      win_idx = IW'(FAV);
    end else if (oth_hit) begin
      win     = 1'b1;
      win_idx = oth_idx;
    end else if (fav_req) begin
      win     = 1'b1;
      win_idx = IW'(FAV);
    end
  end
endmodule

// File: rtl/arb_top.sv
module arb_top
  import arb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int FAV_SLOT  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prio_en,
  input  logic [NUM_SLOTS-1:0] req,
  input  logic [NUM_SLOTS-1:0] done,
  output logic [NUM_SLOTS-1:0] gnt
);
  localparam int IW = $clog2(NUM_SLOTS);
  localparam logic [NUM_SLOTS-1:0] FAV_MASK = NUM_SLOTS'(1) << FAV_SLOT;

  logic [NUM_SLOTS-1:0] gnt_q;
  logic [IW-1:0]        rr_ptr_q, oth_ptr_q;
  logic                 fav_turn_q;

  logic          all_hit, oth_hit, win;
  logic [IW-1:0] all_idx, oth_idx, win_idx;
  logic          busy, release_now;
  arb_mode_e     mode;

  assign busy        = |gnt_q;
  assign release_now = |(gnt_q & done);
  assign mode        = prio_en ? MODE_FAVOUR : MODE_ROTATE;

  arb_rr_pick #(.N(NUM_SLOTS), .IW(IW)) u_pick_all (
    .req(req), .start(rr_ptr_q), .hit(all_hit), .idx(all_idx)
  );

  arb_rr_pick #(.N(NUM_SLOTS), .IW(IW)) u_pick_oth (
    .req(req & ~FAV_MASK), .start(oth_ptr_q), .hit(oth_hit), .idx(oth_idx)
  );

  arb_select #(.N(NUM_SLOTS), .FAV(FAV_SLOT), .IW(IW)) u_sel (
    .mode(mode), .fav_turn(fav_turn_q), .fav_req(req[FAV_SLOT]),
    .all_hit(all_hit), .all_idx(all_idx),
    .oth_hit(oth_hit), .oth_idx(oth_idx),
    .win(win), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q      <= '0;
      rr_ptr_q   <= '0;
      oth_ptr_q  <= '0;
      fav_turn_q <= 1'b1;
    end else if (busy) begin
      if (release_now) gnt_q <= '0;
    end else if (win) begin
      gnt_q    <= NUM_SLOTS'(1) << win_idx;
      rr_ptr_q <= IW'(slot_after(int'(win_idx), NUM_SLOTS));
      if (int'(win_idx) == FAV_SLOT) begin
        fav_turn_q <= 1'b0;
      end else begin
        fav_turn_q <= 1'b1;
        oth_ptr_q  <= IW'(slot_after(int'(win_idx), NUM_SLOTS));
      end
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 prio_en,
  input logic [NUM_SLOTS-1:0] req,
  input logic [NUM_SLOTS-1:0] done,
  input logic [NUM_SLOTS-1:0] gnt
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  a_r2_lone_req: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && $countones(req) == 1) |=> (gnt == $past(req)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && (gnt & done) == '0) |=> (gnt == $past(gnt)));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    ((gnt & done) != '0) |=> (gnt == '0));

  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> (gnt == '0));

  a_r10_req_only: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0) |=> ((gnt & ~$past(req)) == '0));
endmodule

bind arb_top arb_chk #(.NUM_SLOTS(NUM_SLOTS)) u_arb_chk (
  .clk(clk), .rst(rst), .prio_en(prio_en), .req(req), .done(done), .gnt(gnt)
);

// File: tb/tb_arb_top.sv
module tb_arb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         prio_en = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] gnt;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  arb_top #(.NUM_SLOTS(N), .FAV_SLOT(3)) dut (
    .clk(clk), .rst(rst), .prio_en(prio_en), .req(req), .done(done), .gnt(gnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; done = '0; prio_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int idx_of(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Wait for a grant, hold the transfer for 'hold' cycles, then pulse done.
  task automatic serve(input string tag, input int exp, input int hold);
    int w = 0;
    int who;
    while (gnt == '0 && w < 50) begin
      @(negedge clk);
      w++;
    end
    who = idx_of(gnt);
    check($countones(gnt) == 1, "R1", $countones(gnt), 1);
    check(who == exp, tag, who, exp);
    for (int c = 0; c < hold; c++) begin
      @(negedge clk);
      check(gnt == (N'(1) << exp), "R5", gnt, N'(1) << exp);
    end
    done[who] = 1'b1;
    @(negedge clk);
    done = '0;
    check(gnt == '0, "R6", gnt, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(gnt == '0, "R1", gnt, 0);
  endtask

  task automatic t_lone();
    do_reset();
    req = 4'b0100;
    @(negedge clk);
    check(gnt == 4'b0100, "R2", gnt, 4);
    serve("R2", 2, 1);
    req = '0;
  endtask

  task automatic t_rotate();
    int exp_seq[5] = '{0, 1, 2, 3, 0};
    int exp_gap[3] = '{1, 3, 1};
    do_reset();
    req = 4'b1111;
    foreach (exp_seq[i]) serve("R3", exp_seq[i], 2);
    do_reset();
    req = 4'b1010;
    foreach (exp_gap[i]) serve("R3", exp_gap[i], 1);
    req = '0;
  endtask

  task automatic t_favour();
    int exp_seq[8] = '{3, 0, 3, 1, 3, 2, 3, 0};
    do_reset();
    prio_en = 1'b1;
    req = 4'b1111;
    foreach (exp_seq[i]) serve("R4", exp_seq[i], 1);
    req = '0;
  endtask

  task automatic t_gap();
    do_reset();
    req = 4'b0011;
    @(negedge clk);
    check(gnt == 4'b0001, "R6", gnt, 1);
    done[0] = 1'b1;
    @(negedge clk);
    done = '0;
    check(gnt == '0, "R6", gnt, 0);
    @(negedge clk);
    check(gnt == 4'b0010, "R6", gnt, 2);
    serve("R6", 1, 0);
    req = '0;
  endtask

  task automatic t_ignore();
    do_reset();
    req = 4'b0001;
    @(negedge clk);
    req = 4'b1111;
    done = 4'b1110;
    prio_en = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(gnt == 4'b0001, "R5", gnt, 1);
    end
    done = '0;
    serve("R5", 0, 0);
    serve("R5", 3, 0);
    req = '0;
  endtask

  task automatic t_idle();
    do_reset();
    req = 4'b0010;
    serve("R7", 1, 0);
    req = '0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(gnt == '0, "R7", gnt, 0);
    end
    req = 4'b1111;
    serve("R7", 2, 0);
    req = '0;
  endtask

  task automatic t_sample();
    do_reset();
    req = 4'b0001;
    @(negedge clk);
    req = 4'b1111;
    prio_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    prio_en = 1'b0;
    serve("R8", 0, 1);
    serve("R8", 1, 0);
    req = '0;
  endtask

  task automatic t_fav_skip();
    int exp_a[3] = '{0, 2, 0};
    int exp_b[4] = '{3, 0, 3, 0};
    do_reset();
    prio_en = 1'b1;
    req = 4'b0101;
    foreach (exp_a[i]) serve("R9", exp_a[i], 0);
    do_reset();
    prio_en = 1'b1;
    req = 4'b1001;
    foreach (exp_b[i]) serve("R9", exp_b[i], 0);
    do_reset();
    prio_en = 1'b1;
    req = 4'b1000;
    serve("R9", 3, 0);
    serve("R9", 3, 0);
    req = '0;
  endtask

  task automatic t_req_only();
    do_reset();
    req = '0;
    @(negedge clk);
    check(gnt == '0, "R10", gnt, 0);
    req = 4'b1000;
    @(negedge clk);
    check(gnt == 4'b1000, "R10", gnt, 8);
    serve("R10", 3, 0);
    req = '0;
  endtask

  initial begin
    t_reset();
    t_lone();
    t_rotate();
    t_favour();
    t_gap();
    t_ignore();
    t_idle();
    t_sample();
    t_fav_skip();
    t_req_only();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule